// File: doc/BRIEF.md
# Encrypted Key Load Controller

This block manages cipher keys for two crypto-context slots. Each slot holds a key, an IV, a salt and a saved byte count. Software selects the active slot and key handling through a small control word. A key can be written in plaintext. It can also be written wrapped, meaning encrypted under a key-encryption key (KEK). The KEK has a write-only register, and the only place it reaches is the cipher engine.

When a wrapped key is written, the controller unwraps it by itself. It uses a shared external DES engine in CBC mode, with the slot's salt as the IV. A single-DES key is one 64-bit block. A triple-DES key is three blocks, and each block is decrypted under the triple-DES KEK. The engine's own latency is roughly 6 or 36 cycles, and the controller tolerates any latency.

Upstream data may arrive before the key is ready. The controller's process-enable output stays low until the active slot's key is ready. Reusing a slot that is already loaded never starts a new unwrap. A configuration input can forbid plaintext key loads. A forbidden plaintext key write is dropped and raises a sticky error.

Top module: `keyload_ctrl`

## Requirements
- R1: A key write (wr_fld_i = 0) made while control bit 15 is 1 is wrapped. It clears that slot's ready flag on the next cycle. It issues one single-cycle engine request per block: 1 request when control bit 14 is 0 (DES) and 3 requests when bit 14 is 1 (triple DES).
- R2: The unwrapped key is computed as P0 = D(C0) xor salt and Pi = D(Ci) xor C(i-1). Block i occupies bits [64i+63:64i]. The engine key output carries the KEK, and the engine mode output carries bit 14. For a DES key, bits above 63 of the result are zero.
- R3: When unwrapping finishes, the slot's ready flag is set and act_key_o shows the plaintext key while that slot is active.
- R4: proc_en_o is high only when data_pend_i is high and the active slot (control bit 0) is ready. Data written before the key is ready is held until unwrapping completes.
- R5: Changing the active slot through a control write, with no key write, issues no engine request and leaves both keys unchanged.
- R6: If allow_plain_i is 0, a plaintext key write is discarded and err_o is set. err_o then stays set until reset. If allow_plain_i is 1, a plaintext key is stored and its slot is ready on the next cycle.
- R7: Wrapped key loads are accepted whatever the value of allow_plain_i.
- R8: When both slots have wrapped keys pending, slot 0 is unwrapped first and slot 1 next. Both end with their own correct keys.
- R9: If a slot's key is rewritten while its unwrap is in flight, the stale result is dropped and the new key is unwrapped and committed.
- R10: Field writes with wr_fld_i = 1 (IV), 2 (salt) and 3 (byte count) go to the selected slot. act_iv_o and act_cnt_o follow the active slot.
- R11: After reset, key_rdy_o, err_o, des_req_o and proc_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| allow_plain_i | input | 1 | Permits plaintext key loads when 1 |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 16 | Control word: bit 15 wrapped, bit 14 triple DES, bit 0 active slot |
| wr_en_i | input | 1 | Context field write strobe |
| wr_ctx_i | input | 1 | Slot addressed by a field write |
| wr_fld_i | input | 2 | Field: 0 key, 1 IV, 2 salt, 3 byte count |
| wr_data_i | input | 192 | Field or KEK write data |
| kek_we_i | input | 1 | KEK write strobe, takes wr_data_i |
| data_pend_i | input | 1 | Input data waiting to be processed |
| des_done_i | input | 1 | Engine block result valid |
| des_blk_i | input | 64 | Engine decrypted block |
| des_req_o | output | 1 | Engine block request pulse |
| des_tdes_o | output | 1 | Engine mode: 1 triple DES |
| des_blk_o | output | 64 | Ciphertext block to engine |
| des_kek_o | output | 192 | KEK to engine |
| key_rdy_o | output | 2 | Per-slot key ready |
| err_o | output | 1 | Sticky refused-plaintext-load flag |
| proc_en_o | output | 1 | Processing of pending data permitted |
| act_key_o | output | 192 | Active slot key |
| act_iv_o | output | 64 | Active slot IV |
| act_cnt_o | output | 32 | Active slot saved byte count |

## Verification
Random wrapped loads are driven with random ciphertexts, salts, slots and modes. The bench engine model answers with random latency. This separates the chaining order, the use of the salt against the previous ciphertext, and the one-block versus three-block request count. Directed cases cover the rest. One pair of loads puts both slots pending at once, which checks service order. One key is rewritten during its own unwrap, which exposes a commit of a stale result. Plaintext loads are tried with the permission bit both clear and set. Slot switches are made without key writes, which shows any needless re-unwrap.

// File: rtl/keyload_pkg.sv
package keyload_pkg;
  typedef enum logic [1:0] {
    FLD_KEY  = 2'd0,
    FLD_IV   = 2'd1,
    FLD_SALT = 2'd2,
    FLD_CNT  = 2'd3
  } fld_e;

  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned WRAP_BIT = 15;
  localparam int unsigned TDES_BIT = 14;
  localparam int unsigned ACT_BIT  = 0;
  localparam int unsigned NCTX     = 2;
endpackage

// File: rtl/keyctx_bank.sv
module keyctx_bank
  import keyload_pkg::*;
#(
  parameter int unsigned BLK_W = 64,
  parameter int unsigned KEY_W = 3 * BLK_W,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic             key_tdes_i,
  input  logic             fld_we_i,
  input  logic             ctx_i,
  input  logic [1:0]       fld_i,
  input  logic [KEY_W-1:0] data_i,
  input  logic             commit_i,
  input  logic             commit_ctx_i,
  input  logic [KEY_W-1:0] commit_key_i,
  input  logic             act_ctx_i,
  input  logic             sel_ctx_i,
  output logic [KEY_W-1:0] act_key_o,
  output logic [BLK_W-1:0] act_iv_o,
  output logic [CNT_W-1:0] act_cnt_o,
  output logic [KEY_W-1:0] sel_key_o,
  output logic [BLK_W-1:0] sel_salt_o,
  output logic             sel_tdes_o
);
  logic [KEY_W-1:0] key_q  [NCTX];
  logic [BLK_W-1:0] iv_q   [NCTX];
  logic [BLK_W-1:0] salt_q [NCTX];
  logic [CNT_W-1:0] cnt_q  [NCTX];
  logic             tdes_q [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q[c]  <= '0;
        iv_q[c]   <= '0;
        salt_q[c] <= '0;
        cnt_q[c]  <= '0;
        tdes_q[c] <= 1'b0;
      end else begin
        // a fresh key write wins over a commit in the same cycle
        if (key_we_i && ctx_i == c[0]) begin
          key_q[c]  <= data_i;
          tdes_q[c] <= key_tdes_i;
        end else if (commit_i && commit_ctx_i == c[0]) begin
          key_q[c] <= commit_key_i;
        end
        if (fld_we_i && ctx_i == c[0]) begin
          unique case (fld_i)
            FLD_IV:   iv_q[c]   <= data_i[BLK_W-1:0];
            FLD_SALT: salt_q[c] <= data_i[BLK_W-1:0];
            FLD_CNT:  cnt_q[c]  <= data_i[CNT_W-1:0];
            default:  ;
          endcase
        end
      end
    end
  end

  assign act_key_o  = key_q[act_ctx_i];
  assign act_iv_o   = iv_q[act_ctx_i];
  assign act_cnt_o  = cnt_q[act_ctx_i];
  assign sel_key_o  = key_q[sel_ctx_i];
  assign sel_salt_o = salt_q[sel_ctx_i];
  assign sel_tdes_o = tdes_q[sel_ctx_i];
endmodule

// File: rtl/unwrap_seq.sv
module unwrap_seq #(
  parameter int unsigned BLK_W = 64,
  parameter int unsigned NBLK  = 3,
  parameter int unsigned KEY_W = NBLK * BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tdes_i,
  input  logic [KEY_W-1:0] cipher_i,
  input  logic [BLK_W-1:0] salt_i,
  output logic             des_req_o,
  output logic             des_tdes_o,
  output logic [BLK_W-1:0] des_blk_o,
  input  logic             des_done_i,
  input  logic [BLK_W-1:0] des_blk_i,
  output logic             fin_o,
  output logic [KEY_W-1:0] plain_o
);
  localparam int unsigned IDX_W = $clog2(NBLK);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e              st_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [KEY_W-1:0] cipher_q, plain_q;
  logic [BLK_W-1:0] prev_q;
  logic             tdes_q, fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      cipher_q <= '0;
      plain_q  <= '0;
      prev_q   <= '0;
      tdes_q   <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cipher_q <= cipher_i;
          prev_q   <= salt_i;
          plain_q  <= '0;
          tdes_q   <= tdes_i;
          idx_q    <= '0;
          last_q   <= tdes_i ? IDX_W'(NBLK - 1) : '0;
          st_q     <= S_ISSUE;
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (des_done_i) begin
          plain_q[idx_q*BLK_W +: BLK_W] <= des_blk_i ^ prev_q;
          prev_q <= cipher_q[idx_q*BLK_W +: BLK_W];
          if (idx_q == last_q) begin
            fin_q <= 1'b1;
            st_q  <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign des_req_o  = (st_q == S_ISSUE);
  assign des_tdes_o = tdes_q;
  assign des_blk_o  = cipher_q[idx_q*BLK_W +: BLK_W];
  assign fin_o      = fin_q;
  assign plain_o    = plain_q;
endmodule

// File: rtl/keyload_ctrl.sv
module keyload_ctrl
  import keyload_pkg::*;
#(
  parameter int unsigned BLK_W = 64,
  parameter int unsigned NBLK  = 3,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned KEY_W = NBLK * BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              allow_plain_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wr_en_i,
  input  logic              wr_ctx_i,
  input  logic [1:0]        wr_fld_i,
  input  logic [KEY_W-1:0]  wr_data_i,
  input  logic              kek_we_i,
  input  logic              data_pend_i,
  input  logic              des_done_i,
  input  logic [BLK_W-1:0]  des_blk_i,
  output logic              des_req_o,
  output logic              des_tdes_o,
  output logic [BLK_W-1:0]  des_blk_o,
  output logic [KEY_W-1:0]  des_kek_o,
  output logic [NCTX-1:0]   key_rdy_o,
  output logic              err_o,
  output logic              proc_en_o,
  output logic [KEY_W-1:0]  act_key_o,
  output logic [BLK_W-1:0]  act_iv_o,
  output logic [CNT_W-1:0]  act_cnt_o
);
  logic              wrap_q, tdes_q, act_q;
  logic [KEY_W-1:0]  kek_q;
  logic [NCTX-1:0]   rdy_q, pend_q;
  logic              busy_q, cur_q, stale_q, err_q;

  logic              key_wr, accept, start, start_ctx, hit_cur, fin, commit;
  logic [KEY_W-1:0]  sel_key, plain;
  logic [BLK_W-1:0]  sel_salt;
  logic              sel_tdes;

  assign key_wr    = wr_en_i && (wr_fld_i == FLD_KEY);
  assign accept    = key_wr && (wrap_q || allow_plain_i);
  assign start     = !busy_q && (|pend_q);
  assign start_ctx = pend_q[0] ? 1'b0 : 1'b1;
  // a key write landing on the slot being unwrapped makes that result stale
  assign hit_cur   = accept && ((busy_q && cur_q == wr_ctx_i) ||
                                (start && start_ctx == wr_ctx_i));
  assign commit    = fin && !stale_q && !hit_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrap_q <= 1'b0;
      tdes_q <= 1'b0;
      act_q  <= 1'b0;
      kek_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        wrap_q <= ctrl_i[WRAP_BIT];
        tdes_q <= ctrl_i[TDES_BIT];
        act_q  <= ctrl_i[ACT_BIT];
      end
      if (kek_we_i) kek_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      cur_q   <= 1'b0;
      stale_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start) begin
        busy_q            <= 1'b1;
        cur_q             <= start_ctx;
        pend_q[start_ctx] <= 1'b0;
        stale_q           <= 1'b0;
      end
      if (fin) begin
        busy_q <= 1'b0;
        if (commit) rdy_q[cur_q] <= 1'b1;
      end
      if (hit_cur) stale_q <= 1'b1;
      if (accept) begin
        pend_q[wr_ctx_i] <= wrap_q;
        rdy_q[wr_ctx_i]  <= !wrap_q;
      end
      if (key_wr && !accept) err_q <= 1'b1;
    end
  end

  keyctx_bank #(.BLK_W(BLK_W), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_we_i     (accept),
    .key_tdes_i   (tdes_q),
    .fld_we_i     (wr_en_i && !key_wr),
    .ctx_i        (wr_ctx_i),
    .fld_i        (wr_fld_i),
    .data_i       (wr_data_i),
    .commit_i     (commit),
    .commit_ctx_i (cur_q),
    .commit_key_i (plain),
    .act_ctx_i    (act_q),
    .sel_ctx_i    (start_ctx),
    .act_key_o    (act_key_o),
    .act_iv_o     (act_iv_o),
    .act_cnt_o    (act_cnt_o),
    .sel_key_o    (sel_key),
    .sel_salt_o   (sel_salt),
    .sel_tdes_o   (sel_tdes)
  );

  unwrap_seq #(.BLK_W(BLK_W), .NBLK(NBLK), .KEY_W(KEY_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .tdes_i     (sel_tdes),
    .cipher_i   (sel_key),
    .salt_i     (sel_salt),
    .des_req_o  (des_req_o),
    .des_tdes_o (des_tdes_o),
    .des_blk_o  (des_blk_o),
    .des_done_i (des_done_i),
    .des_blk_i  (des_blk_i),
    .fin_o      (fin),
    .plain_o    (plain)
  );

  assign des_kek_o = kek_q;
  assign key_rdy_o = rdy_q;
  assign err_o     = err_q;
  assign proc_en_o = data_pend_i && rdy_q[act_q];
endmodule

// File: rtl/keyload_chk.sv
module keyload_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       allow_plain_i,
  input logic       ctrl_we_i,
  input logic       wr_en_i,
  input logic       wr_ctx_i,
  input logic [1:0] wr_fld_i,
  input logic       wrap_i,
  input logic       act_i,
  input logic       des_req_o,
  input logic [1:0] key_rdy_o,
  input logic       err_o,
  input logic       proc_en_o
);
  logic key_wr;
  assign key_wr = wr_en_i && wr_fld_i == 2'd0;

  assert_req_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    des_req_o |=> !des_req_o);

  assert_wrap_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wrap_i) |=> !key_rdy_o[$past(wr_ctx_i)]);

  assert_hold_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wrap_i && wr_ctx_i == act_i && !ctrl_we_i) |=> !proc_en_o);

  assert_refuse_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !wrap_i && !allow_plain_i) |=> err_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind keyload_ctrl keyload_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .allow_plain_i (allow_plain_i),
  .ctrl_we_i     (ctrl_we_i),
  .wr_en_i       (wr_en_i),
  .wr_ctx_i      (wr_ctx_i),
  .wr_fld_i      (wr_fld_i),
  .wrap_i        (wrap_q),
  .act_i         (act_q),
  .des_req_o     (des_req_o),
  .key_rdy_o     (key_rdy_o),
  .err_o         (err_o),
  .proc_en_o     (proc_en_o)
);

// File: tb/keyload_ctrl_bench.sv
`timescale 1ns/1ps
module keyload_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic allow_plain = 1'b1, ctrl_we = 1'b0, wr_en = 1'b0, wr_ctx = 1'b0;
  logic kek_we = 1'b0, data_pend = 1'b0, des_done = 1'b0;
  logic [15:0]  ctrl = '0;
  logic [1:0]   wr_fld = '0;
  logic [191:0] wr_data = '0;
  logic [63:0]  des_blk_in = '0;
  logic         des_req, des_tdes, err, proc_en;
  logic [63:0]  des_blk_out, act_iv;
  logic [191:0] des_kek, act_key;
  logic [1:0]   key_rdy;
  logic [31:0]  act_cnt;

  int checks = 0, fails = 0, req_cnt = 0, eng_wait = 0;
  logic [63:0] eng_blk;
  logic [191:0] kek_val;

  always #4 clk = ~clk;

  keyload_ctrl u_keyload_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .allow_plain_i(allow_plain),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl), .wr_en_i(wr_en), .wr_ctx_i(wr_ctx),
    .wr_fld_i(wr_fld), .wr_data_i(wr_data), .kek_we_i(kek_we),
    .data_pend_i(data_pend), .des_done_i(des_done), .des_blk_i(des_blk_in),
    .des_req_o(des_req), .des_tdes_o(des_tdes), .des_blk_o(des_blk_out),
    .des_kek_o(des_kek), .key_rdy_o(key_rdy), .err_o(err), .proc_en_o(proc_en),
    .act_key_o(act_key), .act_iv_o(act_iv), .act_cnt_o(act_cnt)
  );

  function automatic logic [63:0] dec(logic [63:0] x, logic [191:0] k, bit t);
    return t ? (x ^ k[63:0] ^ k[127:64] ^ {k[159:128], k[191:160]}) : (x ^ k[63:0]);
  endfunction

  function automatic logic [191:0] unwrap(logic [191:0] c, logic [63:0] s,
                                          logic [191:0] k, bit t);
    logic [191:0] r = '0;
    logic [63:0]  p = s;
    for (int i = 0; i < (t ? 3 : 1); i++) begin
      r[i*64 +: 64] = dec(c[i*64 +: 64], k, t) ^ p;
      p = c[i*64 +: 64];
    end
    return r;
  endfunction

  // engine model: random latency, answers at a negedge
  always @(negedge clk) begin
    if (des_done) des_done = 1'b0;
    if (eng_wait > 0) begin
      eng_wait = eng_wait - 1;
      if (eng_wait == 0) begin
        des_blk_in = dec(eng_blk, des_kek, des_tdes);
        des_done = 1'b1;
      end
    end
    if (rst_n && des_req) begin
      req_cnt  = req_cnt + 1;
      eng_blk  = des_blk_out;
      eng_wait = 1 + int'($urandom % 6);
    end
  end

  task automatic chk(bit ok, string tag, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(bit wrap, bit tdes, bit ctx);
    ctrl = '0; ctrl[15] = wrap; ctrl[14] = tdes; ctrl[0] = ctx;
    ctrl_we = 1'b1; @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr(bit c, logic [1:0] f, logic [191:0] d);
    wr_ctx = c; wr_fld = f; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rdy(bit c);
    for (int n = 0; n < 2000 && !key_rdy[c]; n++) @(negedge clk);
    for (int n = 0; n < 3; n++) @(negedge clk);
  endtask

  function automatic logic [191:0] rnd192();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    int base;
    logic [191:0] c0, c1, c2, exp0, exp1;
    logic [63:0]  s0, s1;
    bit t, c;
    void'($urandom(32'h5eed_1234));
    #1;
    @(negedge clk);
    @(negedge clk);
    chk(key_rdy == 0 && !err && !des_req && !proc_en, "R11 reset outputs",
        {key_rdy, err, des_req, proc_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    kek_val = rnd192();
    wr_data = kek_val; kek_we = 1'b1; @(negedge clk); kek_we = 1'b0;
    data_pend = 1'b1;

    // random wrapped loads
    for (int k = 0; k < 16; k++) begin
      c  = k[0] ^ ($urandom % 2 == 1);
      t  = ($urandom % 2) == 1;
      s0 = {$urandom, $urandom};
      c0 = rnd192();
      wr(c, 2'd2, {128'd0, s0});
      set_ctrl(1'b1, t, c);
      base = req_cnt;
      wr(c, 2'd0, c0);
      chk(!proc_en, "R4 data held while unwrapping", proc_en, 0);
      chk(!key_rdy[c], "R1 ready cleared", key_rdy, 0);
      wait_rdy(c);
      chk(req_cnt - base == (t ? 3 : 1), "R1 engine request count", req_cnt - base, t ? 3 : 1);
      exp0 = unwrap(c0, s0, kek_val, t);
      chk(act_key == exp0, "R2 R3 unwrapped key", act_key, exp0);
      chk(proc_en, "R4 released when ready", proc_en, 1);
    end

    // both slots pending: slot 0 then slot 1
    s0 = {$urandom, $urandom}; s1 = {$urandom, $urandom};
    c0 = rnd192(); c1 = rnd192();
    wr(1'b0, 2'd2, {128'd0, s0});
    wr(1'b1, 2'd2, {128'd0, s1});
    set_ctrl(1'b1, 1'b1, 1'b0);
    base = req_cnt;
    wr(1'b0, 2'd0, c0);
    wr(1'b1, 2'd0, c1);
    for (int n = 0; n < 2000 && !key_rdy[0]; n++) @(negedge clk);
    chk(key_rdy == 2'b01, "R8 slot 0 served first", key_rdy, 2'b01);
    wait_rdy(1'b1);
    exp0 = unwrap(c0, s0, kek_val, 1'b1);
    exp1 = unwrap(c1, s1, kek_val, 1'b1);
    chk(act_key == exp0, "R8 slot 0 key", act_key, exp0);
    chk(req_cnt - base == 6, "R8 request count", req_cnt - base, 6);

    // reuse: switching slots must not unwrap again
    base = req_cnt;
    set_ctrl(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk(act_key == exp1, "R8 slot 1 key", act_key, exp1);
    set_ctrl(1'b1, 1'b1, 1'b0);
    set_ctrl(1'b1, 1'b1, 1'b1);
    for (int n = 0; n < 20; n++) @(negedge clk);
    chk(req_cnt == base, "R5 no re-unwrap on reuse", req_cnt, base);
    chk(act_key == exp1 && key_rdy == 2'b11, "R5 keys kept", act_key, exp1);

    // rewrite during unwrap
    set_ctrl(1'b1, 1'b1, 1'b0);
    c0 = rnd192(); c2 = rnd192();
    base = req_cnt;
    wr(1'b0, 2'd0, c0);
    for (int n = 0; n < 100 && req_cnt == base; n++) @(negedge clk);
    wr(1'b0, 2'd0, c2);
    wait_rdy(1'b0);
    exp0 = unwrap(c2, s0, kek_val, 1'b1);
    chk(act_key == exp0, "R9 stale result dropped", act_key, exp0);

    // plaintext refused
    allow_plain = 1'b0;
    set_ctrl(1'b0, 1'b0, 1'b0);
    c1 = rnd192();
    wr(1'b0, 2'd0, c1);
    chk(err && act_key == exp0 && key_rdy[0], "R6 plaintext refused", act_key, exp0);
    // wrapped still allowed
    set_ctrl(1'b1, 1'b0, 1'b0);
    c0 = rnd192();
    wr(1'b0, 2'd0, c0);
    wait_rdy(1'b0);
    exp0 = unwrap(c0, s0, kek_val, 1'b0);
    chk(act_key == exp0, "R7 wrapped load with plaintext disabled", act_key, exp0);
    chk(err, "R6 error sticky", err, 1);
    // plaintext permitted
    allow_plain = 1'b1;
    set_ctrl(1'b0, 1'b0, 1'b1);
    c1 = rnd192();
    base = req_cnt;
    wr(1'b1, 2'd0, c1);
    chk(key_rdy[1] && act_key == c1, "R6 plaintext stored", act_key, c1);
    chk(req_cnt == base, "R6 plaintext needs no engine", req_cnt, base);

    // per-slot IV and count
    wr(1'b0, 2'd1, 192'h1111_2222_3333_4444);
    wr(1'b1, 2'd1, 192'h5555_6666_7777_8888);
    wr(1'b0, 2'd3, 192'h0000_00aa);
    wr(1'b1, 2'd3, 192'h0000_00bb);
    chk(act_iv == 64'h5555_6666_7777_8888 && act_cnt == 32'hbb, "R10 slot 1 fields",
        {act_iv, act_cnt}, {64'h5555_6666_7777_8888, 32'hbb});
    set_ctrl(1'b0, 1'b0, 1'b0);
    chk(act_iv == 64'h1111_2222_3333_4444 && act_cnt == 32'haa, "R10 slot 0 fields",
        {act_iv, act_cnt}, {64'h1111_2222_3333_4444, 32'haa});
    data_pend = 1'b0;
    @(negedge clk);
    chk(!proc_en, "R4 no pending data", proc_en, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule